// File: doc/BRIEF.md
# GPIO Port Interrupt Detector

This block watches three banks of eight general-purpose input lines and turns their activity into interrupt requests. Every line is configured on its own. One bit selects whether it senses a level or an edge. A second bit selects the active direction: high or low for level sensing, rising or falling for edge sensing. A third bit lets the line report at all. Edge events are caught in sticky pending flags. Software clears a flag by writing a one to the matching bit of the port's clear register.

The first two ports (A and B) are merged into one summary interrupt. The third port (F) drives eight separate interrupt outputs, one for each pin. Software reaches every control and status byte over a small byte-wide register bus. Writes take effect at the clock edge, and reads are combinational on the address. The recommended way to change a line's sensing is to clear that port's enable byte first, rewrite the two sensing bytes, and then restore the enable byte.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every configuration byte and every pending flag is zero, so irq_ab and irq_f are both zero and every register reads 0x00.
- R2: The byte registers sit at these addresses (sense, polarity, clear, enable): port A 0x90/0x94/0x98/0x9C, port B 0xAC/0xB0/0xB4/0xB8, port F 0x4C/0x50/0x54/0x58. Sense, polarity and enable read back the last byte written. The clear register always reads 0x00.
- R3: A line with sense bit 0 and polarity bit 1 reports while its synchronised input is high. A pin change becomes visible two clock edges after it is applied.
- R4: A line with sense bit 0 and polarity bit 0 reports while its synchronised input is low.
- R5: A line with sense bit 1 and polarity bit 1 latches a pending flag on a rising edge, three clock edges after the pin rises. The flag stays set after the pin falls again. A falling edge does not set it.
- R6: A line with sense bit 1 and polarity bit 0 latches a pending flag on a falling edge. A rising edge does not set it.
- R7: Writing a byte to a port's clear register clears exactly the pending flags whose bits are 1 in that byte. Other flags are left as they were.
- R8: If an edge is detected in the same cycle as a clearing write for that line, the line stays pending.
- R9: A line whose enable bit is 0 does not report. Edges that occur while it is disabled are not recorded, so enabling it later does not raise a stale request.
- R10: irq_ab is high when any enabled line of port A or port B reports. The status bytes for A, B and F are readable at 0xA0, 0xBC and 0x5C, and bit i of each is line i's report. Global line number n maps to port n>>3 and bit n&7, with ports A, B, F in pin_in order.
- R11: irq_f[i] follows only line i of port F. Activity on ports A and B never changes irq_f.
- R12: A write to an address outside the map changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address for reads and writes |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr, combinational |
| pin_in | input | 24 | Asynchronous input lines: A in [7:0], B in [15:8], F in [23:16] |
| irq_ab | output | 1 | Summary request for ports A and B |
| irq_f | output | 8 | Per-pin requests for port F |

## Verification
The bench builds the block with its default parameters: eight lines per port and an eight-bit address. That puts every mapped offset, both summary groupings and the full per-pin output of port F within reach of a byte-wide driver. On port F, four lines are set to the four sensing modes at the same time. This shows that the modes and the clear mask act per bit and never spill into a neighbour. The bench also places the clear write exactly on the cycle when an edge is detected, counting both synchroniser stages and the edge-history register, so the pending-wins rule is exercised at its one critical cycle.

// File: rtl/gpio_irq_pkg.sv
// Shared constants, types and the register map for the GPIO interrupt detector.
// Assumes three ports in the order A, B, F; port index 2 is the per-pin port.
package gpio_irq_pkg;

    localparam int LINES  = 8;
    localparam int NPORTS = 3;
    localparam int ADDR_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        addr_t sense;
        addr_t pol;
        addr_t clr;
        addr_t en;
        addr_t stat;
    } port_map_t;

    // Byte addresses of one port's registers; index 0=A, 1=B, 2=F.
    function automatic port_map_t port_map(input int idx);
        port_map_t m;
        case (idx)
            0:       m = '{sense: 8'h90, pol: 8'h94, clr: 8'h98, en: 8'h9C, stat: 8'hA0};
            1:       m = '{sense: 8'hAC, pol: 8'hB0, clr: 8'hB4, en: 8'hB8, stat: 8'hBC};
            default: m = '{sense: 8'h4C, pol: 8'h50, clr: 8'h54, en: 8'h58, stat: 8'h5C};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
// Two-stage synchroniser for a vector of asynchronous input lines.
// Assumes the inputs are slow compared with clk; no debounce is done.
module gpio_irq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Capture the raw inputs, then retime them once more.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_irq_regs.sv
// Register slice of one port: sense, polarity and enable bytes, a write-only
// clear strobe, and a read path for the port's bytes and its status.
// Assumes one write per cycle; reads are combinational on addr.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int PORT_IDX = 0,
    parameter int LINES_P  = 8,
    parameter int ADDR_P   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_P-1:0]  addr,
    input  logic [LINES_P-1:0] wdata,
    input  logic [LINES_P-1:0] status,
    output logic [LINES_P-1:0] sense,
    output logic [LINES_P-1:0] pol,
    output logic [LINES_P-1:0] en,
    output logic [LINES_P-1:0] clr_mask,
    output logic [LINES_P-1:0] rd_data
);

    localparam port_map_t MAP = port_map(PORT_IDX);

    logic [LINES_P-1:0] sense_q;
    logic [LINES_P-1:0] pol_q;
    logic [LINES_P-1:0] en_q;

    // Load configuration bytes on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= '0;
            pol_q   <= '0;
            en_q    <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_P'(MAP.sense)) sense_q <= wdata;
            if (addr == ADDR_P'(MAP.pol))   pol_q   <= wdata;
            if (addr == ADDR_P'(MAP.en))    en_q    <= wdata;
        end
    end

    // One-cycle clear strobe taken from a write to the clear address.
    always_comb begin
        clr_mask = '0;
        if (wr_en && addr == ADDR_P'(MAP.clr)) clr_mask = wdata;
    end

    // Read mux; zero when the address belongs to no byte of this port.
    always_comb begin
        rd_data = '0;
        if (addr == ADDR_P'(MAP.sense)) rd_data = sense_q;
        if (addr == ADDR_P'(MAP.pol))   rd_data = pol_q;
        if (addr == ADDR_P'(MAP.en))    rd_data = en_q;
        if (addr == ADDR_P'(MAP.stat))  rd_data = status;
    end

    assign sense = sense_q;
    assign pol   = pol_q;
    assign en    = en_q;

endmodule

// File: rtl/gpio_irq_detect.sv
// Per-line detector of one port: level qualification, edge history and
// sticky edge flags, producing the port's status vector.
// Assumes lvl is already synchronised to clk.
module gpio_irq_detect #(
    parameter int LINES_P = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINES_P-1:0] lvl,
    input  logic [LINES_P-1:0] sense,
    input  logic [LINES_P-1:0] pol,
    input  logic [LINES_P-1:0] en,
    input  logic [LINES_P-1:0] clr_mask,
    output logic [LINES_P-1:0] status
);

    logic [LINES_P-1:0] prev_q;
    logic [LINES_P-1:0] flag_q;
    logic [LINES_P-1:0] rise;
    logic [LINES_P-1:0] fall;
    logic [LINES_P-1:0] hit;
    logic [LINES_P-1:0] lvl_active;

    // Edge events for enabled edge lines in the chosen direction.
    always_comb begin
        rise       = lvl & ~prev_q;
        fall       = ~lvl & prev_q;
        hit        = sense & en & ((pol & rise) | (~pol & fall));
        lvl_active = ~(lvl ^ pol);
    end

    // Keep edge history; set flags on a hit, which beats a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            flag_q <= '0;
        end else begin
            prev_q <= lvl;
            flag_q <= (flag_q & ~clr_mask) | hit;
        end
    end

    // Report the flag on edge lines and the qualified level on level lines.
    always_comb begin
        status = en & ((sense & flag_q) | (~sense & lvl_active));
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
// Top of the GPIO interrupt detector: three ports of LINES inputs, a shared
// byte register bus, a summary request for the first ports and per-pin
// requests for the last port.
// Assumes pin_in is asynchronous and ordered port A, B, F from bit 0.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int LINES_P = gpio_irq_pkg::LINES,
    parameter int ADDR_P  = gpio_irq_pkg::ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_P-1:0]          addr,
    input  logic [LINES_P-1:0]         wdata,
    output logic [LINES_P-1:0]         rd_data,
    input  logic [NPORTS*LINES_P-1:0]  pin_in,
    output logic                       irq_ab,
    output logic [LINES_P-1:0]         irq_f
);

    localparam int PIN_W     = NPORTS * LINES_P;
    localparam int SHARED_N  = NPORTS - 1;
    localparam int SOLO_IDX  = NPORTS - 1;

    typedef logic [LINES_P-1:0] lanes_t;

    logic [PIN_W-1:0] pin_sync;
    lanes_t sense_q  [NPORTS];
    lanes_t pol_q    [NPORTS];
    lanes_t en_q     [NPORTS];
    lanes_t clr_mask [NPORTS];
    lanes_t stat     [NPORTS];
    lanes_t rd_port  [NPORTS];

    gpio_irq_sync #(.W(PIN_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        gpio_irq_regs #(
            .PORT_IDX (p),
            .LINES_P  (LINES_P),
            .ADDR_P   (ADDR_P)
        ) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .addr     (addr),
            .wdata    (wdata),
            .status   (stat[p]),
            .sense    (sense_q[p]),
            .pol      (pol_q[p]),
            .en       (en_q[p]),
            .clr_mask (clr_mask[p]),
            .rd_data  (rd_port[p])
        );

        gpio_irq_detect #(.LINES_P(LINES_P)) u_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (pin_sync[p*LINES_P +: LINES_P]),
            .sense    (sense_q[p]),
            .pol      (pol_q[p]),
            .en       (en_q[p]),
            .clr_mask (clr_mask[p]),
            .status   (stat[p])
        );
    end

    // Merge the per-port read data; at most one port claims an address.
    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NPORTS; p++) rd_data = rd_data | rd_port[p];
    end

    // Summary request over the shared ports.
    always_comb begin
        irq_ab = 1'b0;
        for (int p = 0; p < SHARED_N; p++) irq_ab = irq_ab | (|stat[p]);
    end

    // Per-pin requests of the last port.
    assign irq_f = stat[SOLO_IDX];

endmodule

// File: rtl/gpio_irq_checker.sv
// Property checker for gpio_irq_ctrl, attached by bind below.
// Assumes default parameters (eight lines, eight-bit addresses).
module gpio_irq_checker
    import gpio_irq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] addr,
    input logic [7:0] wdata,
    input logic       irq_ab,
    input logic [7:0] irq_f,
    input logic [7:0] en_a,
    input logic [7:0] en_b,
    input logic [7:0] en_f,
    input logic [7:0] sense_f
);

    localparam port_map_t MF = port_map(2);

    // R1: the first cycle out of reset has no request.
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (irq_ab == 1'b0 && irq_f == 8'h00));

    // R2: a write to the port F enable byte lands on the next cycle.
    a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == MF.en) |=> (en_f == $past(wdata)));

    // R12: the enable byte only changes on its own address.
    a_r12_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == MF.en) |=> $stable(en_f));

    // R9: a disabled port F line never requests.
    a_r9_f_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_f & ~en_f) == 8'h00));

    // R5: without any register write, a pending edge request does not drop.
    a_r5_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && !$past(!rst_n)) |-> (($past(irq_f) & sense_f & ~irq_f) == 8'h00));

    // R10: the summary request needs some enabled line in A or B.
    a_r10_ab_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ab |-> ((en_a | en_b) != 8'h00));

endmodule

bind gpio_irq_ctrl gpio_irq_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .irq_ab  (irq_ab),
    .irq_f   (irq_f),
    .en_a    (en_q[0]),
    .en_b    (en_q[1]),
    .en_f    (en_q[2]),
    .sense_f (sense_q[2])
);

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rd_data;
    logic [23:0] pins = '0;
    logic        irq_ab;
    logic [7:0]  irq_f;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string     tag;
        int        kind;
        logic [7:0] exp;
    } item_t;

    item_t sb_q[$];
    event  sample_ev;

    always #5 clk = ~clk;

    gpio_irq_ctrl u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rd_data (rd_data),
        .pin_in  (pins),
        .irq_ab  (irq_ab),
        .irq_f   (irq_f)
    );

    // Monitor: pop expected items and compare with what the design shows.
    initial begin
        forever begin
            @(sample_ev);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = rd_data;
                    1:       act = {7'b0, irq_ab};
                    default: act = irq_f;
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
        addr  = 8'h00;
    endtask

    task automatic push(input int kind, input logic [7:0] e, input string tag);
        item_t it;
        it.tag  = tag;
        it.kind = kind;
        it.exp  = e;
        sb_q.push_back(it);
        -> sample_ev;
        #2;
    endtask

    task automatic exp_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        addr = a;
        push(0, e, tag);
    endtask

    task automatic exp_ab(input logic e, input string tag);
        push(1, {7'b0, e}, tag);
    endtask

    task automatic exp_f(input logic [7:0] e, input string tag);
        push(2, e, tag);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            summary();
            $finish;
        end
    end

    // Driver.
    initial begin
        tick(4);
        rst_n = 1'b1;
        tick();

        exp_ab(1'b0, "R1 irq_ab after reset");
        exp_f(8'h00, "R1 irq_f after reset");
        exp_rd(8'hB8, 8'h00, "R1 enable B after reset");
        tick();
        exp_rd(8'h5C, 8'h00, "R1 status F after reset");
        tick();

        wr(8'h90, 8'h0F); exp_rd(8'h90, 8'h0F, "R2 sense A readback");
        wr(8'hB0, 8'hA5); exp_rd(8'hB0, 8'hA5, "R2 polarity B readback");
        wr(8'h58, 8'h3C); exp_rd(8'h58, 8'h3C, "R2 enable F readback");
        tick();
        exp_rd(8'h54, 8'h00, "R2 clear F reads zero");
        tick();

        wr(8'h60, 8'hFF);
        wr(8'h00, 8'hFF);
        exp_rd(8'h58, 8'h3C, "R12 enable F after stray writes");
        tick();
        exp_rd(8'h90, 8'h0F, "R12 sense A after stray writes");
        exp_f(8'h3C, "R4 low-level lines with pins low");
        tick();

        wr(8'h58, 8'h00);
        wr(8'h90, 8'h00);
        wr(8'hB0, 8'h00);

        // Port F: line0 level high, line1 level low, line2 rising, line3 falling.
        wr(8'h4C, 8'h0C);
        wr(8'h50, 8'h05);
        wr(8'h58, 8'h0F);
        exp_f(8'h02, "R4 level-low line active");

        pins[16] = 1'b1;
        tick();
        exp_f(8'h02, "R3 one edge after pin rise");
        tick();
        exp_f(8'h03, "R3 level-high line active");

        pins[17] = 1'b1;
        tick(2);
        exp_f(8'h01, "R4 level-low line released");

        pins[18] = 1'b1;
        tick(2);
        exp_f(8'h01, "R5 rising flag not yet set");
        tick();
        exp_f(8'h05, "R5 rising flag set");
        pins[18] = 1'b0;
        tick(3);
        exp_f(8'h05, "R5 flag sticky after pin falls");

        pins[19] = 1'b1;
        tick(3);
        exp_f(8'h05, "R6 rising edge ignored on falling line");
        pins[19] = 1'b0;
        tick(3);
        exp_f(8'h0D, "R6 falling flag set");

        wr(8'h54, 8'h04);
        exp_f(8'h09, "R7 clear only masked flag");
        exp_rd(8'h5C, 8'h09, "R7 status F readback");
        tick();
        wr(8'h54, 8'h08);
        exp_f(8'h01, "R7 second flag cleared");

        pins[18] = 1'b1;
        tick(2);
        wr(8'h54, 8'h04);
        exp_f(8'h05, "R8 edge wins over same-cycle clear");
        wr(8'h54, 8'h04);
        exp_f(8'h01, "R8 later clear removes flag");

        wr(8'h58, 8'h01);
        exp_f(8'h01, "R9 only enabled level line");
        pins[18] = 1'b0;
        tick(3);
        pins[18] = 1'b1;
        tick(3);
        pins[19] = 1'b1;
        tick(3);
        pins[19] = 1'b0;
        tick(3);
        exp_f(8'h01, "R9 edges while disabled");
        wr(8'h58, 8'h0F);
        exp_f(8'h01, "R9 no stale flag after enable");
        exp_ab(1'b0, "R11 port F does not drive irq_ab");
        tick();

        // Port A line0 rising edge.
        wr(8'h90, 8'h01);
        wr(8'h94, 8'h01);
        wr(8'h9C, 8'h01);
        exp_ab(1'b0, "R10 idle after A setup");
        pins[0] = 1'b1;
        tick(3);
        exp_ab(1'b1, "R10 port A edge raises irq_ab");
        exp_rd(8'hA0, 8'h01, "R10 status A readback");
        exp_f(8'h01, "R11 irq_f unaffected by port A");
        tick();
        wr(8'h98, 8'h01);
        exp_ab(1'b0, "R7 port A flag cleared");

        // Port B line7 level high.
        wr(8'hAC, 8'h00);
        wr(8'hB0, 8'h80);
        wr(8'hB8, 8'h80);
        exp_ab(1'b0, "R10 idle after B setup");
        pins[15] = 1'b1;
        tick(2);
        exp_ab(1'b1, "R10 port B level raises irq_ab");
        exp_rd(8'hBC, 8'h80, "R10 status B readback");
        tick();
        pins[15] = 1'b0;
        tick(2);
        exp_ab(1'b0, "R3 port B level released");

        tick(2);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule